// File: doc/BRIEF.md
# Audio Effects Multiply-Accumulate Datapath

This block is the arithmetic core of a microprogrammed audio effects processor. A sequencer outside the block presents one decoded microinstruction per clock: which input bank to read and where, which operands feed the multiplier and the adder, whether the input is captured in a holding register, and where scratch data is written. The block aligns the chosen input to a common 24-bit signed format. It selects X, Y and B from the input, a 128-word circular scratch RAM, the step's coefficient or internal holding registers, and registers a 26-bit accumulator equal to the scaled product X*Y plus B.

The scratch RAM is addressed relative to a ring position supplied by the sequencer, so a program sees a moving window over it from one sample to the next. At the first step of every sample, the previous accumulator, the fraction register and the Y holding register all read as zero. A step completes every clock in which `stepValid` is high. The block never stalls.

Top module: `audfx_mac`

## Requirements
- R1: `srcIdx` selects the input: 0..31 take `wrkRdData` unchanged, 32..47 take the 20-bit `mixRdData` shifted left 4, 48..49 take the 16-bit `extRdData` shifted left 8, and 50..63 give zero. The result is a 24-bit two's-complement value. The bank addresses are `srcIdx`, `srcIdx-32` and `srcIdx-48`, in their low bits.
- R2: X is the aligned input when `xUseInput`=1. Otherwise X is the signed scratch word at (`tempRdOfs`+`ringPos`) mod 128.
- R3: `yMode` picks the 14-bit signed Y: 0 = the 13-bit fraction register, zero-extended; 1 = `coefWord` arithmetically shifted right by 3; 2 = Y holding bits [23:11], signed; 3 = Y holding bits [15:4], signed 12-bit.
- R4: B is zero when `bForceZero`=1. Otherwise B is the previous accumulator when `bUseAcc`=1, or the sign-extended scratch word at (`tempRdOfs`+`ringPos`) mod 128 when `bUseAcc`=0. B is negated when `bNegate`=1.
- R5: The new accumulator is ((X*Y) arithmetically shifted right by 10, truncated to 26 bits) + B, wrapped to 26 bits two's complement.
- R6: `accOut` is registered and resets to 0. It changes only on a clock edge with `stepValid`=1 and holds otherwise.
- R7: On a valid step with `yHoldLoad`=1, the Y holding register captures the aligned input. The new value is used from the next step; the current step uses the old value.
- R8: On a valid step with `sampleStart`=1, the previous accumulator, the fraction register and the Y holding register read as zero in that step. The two registers are then cleared unless that same step loads them.
- R9: A valid step with `tempWrEn`=1 writes `tempWrData` to scratch word (`tempWrOfs`+`ringPos`) mod 128. Reads in the following steps see the new word. No write happens when `stepValid`=0, and the scratch RAM resets to zero.
- R10: A valid step with `fracWrEn`=1 loads `fracWrData` into the fraction register. The new value is used from the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | Current step is valid and commits at this edge |
| sampleStart | input | 1 | Current step is step 0 of a sample |
| srcIdx | input | 6 | Input source index |
| xUseInput | input | 1 | X from input (1) or scratch (0) |
| yMode | input | 2 | Y operand select |
| bUseAcc | input | 1 | B from previous accumulator (1) or scratch (0) |
| bForceZero | input | 1 | Force B to zero |
| bNegate | input | 1 | Negate B |
| tempRdOfs | input | 7 | Scratch read offset |
| yHoldLoad | input | 1 | Load Y holding register with input |
| coefWord | input | 16 | Coefficient for this step |
| ringPos | input | 7 | Ring position added to scratch offsets |
| tempWrEn | input | 1 | Scratch write enable |
| tempWrOfs | input | 7 | Scratch write offset |
| tempWrData | input | 24 | Scratch write data |
| fracWrEn | input | 1 | Fraction register load enable |
| fracWrData | input | 13 | Fraction register load value |
| wrkRdAddr | output | 5 | Work bank read address |
| wrkRdData | input | 24 | Work bank read data |
| mixRdAddr | output | 4 | Mix bank read address |
| mixRdData | input | 20 | Mix bank read data |
| extRdAddr | output | 1 | External bank read address |
| extRdData | input | 16 | External bank read data |
| accOut | output | 26 | Registered accumulator |

## Verification
The embedded properties assume that the bank read data and the control fields stay stable across the clock edge on which a step commits. They also assume that reset is only asserted between steps. The Y-capture and scratch-write checks compare registered state with the previous cycle's inputs, which is only meaningful under those conditions. The bench drives every field on the falling edge and holds it through the following rising edge. It keeps bank data constant within a step and starts each sequence with `sampleStart`, so expected values never depend on leftovers from earlier tests.

// File: rtl/audfx_mac_pkg.sv
package audfx_mac_pkg;

  typedef enum logic [1:0] {
    SRC_WRK  = 2'd0,
    SRC_MIX  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    B_TEMP = 2'd0,
    B_ACC  = 2'd1,
    B_ZERO = 2'd2
  } bSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    srcSel_e    src;
    logic       xFromTemp;
    logic [1:0] yMode;
    bSel_e      bSel;
    logic       bNeg;
    logic       yLoad;
    logic       fracLoad;
    logic       tempWrite;
    logic       sampleStart;
    logic       commit;
  } macCtrl_t;

endpackage

// File: rtl/audfx_mac_ctrl.sv
module audfx_mac_ctrl
  import audfx_mac_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int WRK_N = 32,
  parameter int MIX_N = 16,
  parameter int EXT_N = 2
) (
  input  logic             stepValid,
  input  logic             sampleStart,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic             xUseInput,
  input  logic [1:0]       yMode,
  input  logic             bUseAcc,
  input  logic             bForceZero,
  input  logic             bNegate,
  input  logic             yHoldLoad,
  input  logic             tempWrEn,
  input  logic             fracWrEn,
  output macCtrl_t         ctrl
);

  localparam int MIX_BASE = WRK_N;
  localparam int EXT_BASE = WRK_N + MIX_N;
  localparam int END_IDX  = EXT_BASE + EXT_N;

  srcSel_e srcSel;

  always_comb begin
    if (int'(srcIdx) < MIX_BASE)      srcSel = SRC_WRK;
    else if (int'(srcIdx) < EXT_BASE) srcSel = SRC_MIX;
    else if (int'(srcIdx) < END_IDX)  srcSel = SRC_EXT;
    else                              srcSel = SRC_NONE;
  end

  always_comb begin
    ctrl.src         = srcSel;
    ctrl.xFromTemp   = !xUseInput;
    ctrl.yMode       = yMode;
    ctrl.bSel        = bForceZero ? B_ZERO : (bUseAcc ? B_ACC : B_TEMP);
    ctrl.bNeg        = bNegate;
    ctrl.yLoad       = stepValid & yHoldLoad;
    ctrl.fracLoad    = stepValid & fracWrEn;
    ctrl.tempWrite   = stepValid & tempWrEn;
    ctrl.sampleStart = sampleStart;
    ctrl.commit      = stepValid;
  end

  // R1: indices past the last bank never select a bank
  always_comb begin
    if (int'(srcIdx) >= END_IDX)
      p_high_idx_none_r1: assert (ctrl.src == SRC_NONE);
  end

endmodule

// File: rtl/audfx_mac_dp.sv
module audfx_mac_dp
  import audfx_mac_pkg::*;
#(
  parameter int DW       = 24,
  parameter int ACC_W    = 26,
  parameter int YW       = 13,
  parameter int COEF_W   = 16,
  parameter int MIX_W    = 20,
  parameter int EXT_W    = 16,
  parameter int TEMP_N   = 128,
  parameter int PROD_SH  = 10,
  parameter int YNAR_LO  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  macCtrl_t                   ctrl,
  input  logic [DW-1:0]              wrkData,
  input  logic [MIX_W-1:0]           mixData,
  input  logic [EXT_W-1:0]           extData,
  input  logic [COEF_W-1:0]          coefWord,
  input  logic [$clog2(TEMP_N)-1:0]  tempRdOfs,
  input  logic [$clog2(TEMP_N)-1:0]  tempWrOfs,
  input  logic [$clog2(TEMP_N)-1:0]  ringPos,
  input  logic [DW-1:0]              tempWrData,
  input  logic [YW-1:0]              fracWrData,
  output logic [ACC_W-1:0]           accOut
);

  localparam int TA_W    = $clog2(TEMP_N);
  localparam int MIX_SH  = DW - MIX_W;
  localparam int EXT_SH  = DW - EXT_W;
  localparam int COEF_SH = COEF_W - YW;
  localparam int YNAR_W  = YW - 1;
  localparam int YNAR_HI = YNAR_LO + YNAR_W - 1;
  localparam int PROD_W  = DW + YW + 1;

  logic [DW-1:0] tempMem [TEMP_N];
  logic [TA_W-1:0] rdAddr, wrAddr;

  logic signed [ACC_W-1:0] accReg, accPrev, bVal, bEff, scaled, accNext;
  logic [YW-1:0]           fracReg, fracEff;
  logic [DW-1:0]           yHold, yEff;
  logic signed [DW-1:0]    inVal, xVal, tempRdVal;
  logic signed [YW:0]      yVal;
  logic signed [PROD_W-1:0] prod, prodSh;

  assign rdAddr    = tempRdOfs + ringPos;
  assign wrAddr    = tempWrOfs + ringPos;
  assign tempRdVal = tempMem[rdAddr];

  // sample start hides the carried state for this step
  assign accPrev = ctrl.sampleStart ? '0 : accReg;
  assign fracEff = ctrl.sampleStart ? '0 : fracReg;
  assign yEff    = ctrl.sampleStart ? '0 : yHold;

  always_comb begin
    unique case (ctrl.src)
      SRC_WRK: inVal = wrkData;
      SRC_MIX: inVal = {mixData, {MIX_SH{1'b0}}};
      SRC_EXT: inVal = {extData, {EXT_SH{1'b0}}};
      default: inVal = '0;
    endcase
  end

  assign xVal = ctrl.xFromTemp ? tempRdVal : inVal;

  always_comb begin
    unique case (ctrl.yMode)
      2'd0:    yVal = {1'b0, fracEff};
      2'd1:    yVal = {coefWord[COEF_W-1], coefWord[COEF_W-1:COEF_SH]};
      2'd2:    yVal = {yEff[DW-1], yEff[DW-1 -: YW]};
      default: yVal = {{(YW+1-YNAR_W){yEff[YNAR_HI]}}, yEff[YNAR_HI:YNAR_LO]};
    endcase
  end

  always_comb begin
    unique case (ctrl.bSel)
      B_ACC:   bVal = accPrev;
      B_TEMP:  bVal = {{(ACC_W-DW){tempRdVal[DW-1]}}, tempRdVal};
      default: bVal = '0;
    endcase
  end

  assign bEff    = ctrl.bNeg ? -bVal : bVal;
  assign prod    = xVal * yVal;
  assign prodSh  = prod >>> PROD_SH;
  assign scaled  = prodSh[ACC_W-1:0];
  assign accNext = scaled + bEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      fracReg <= '0;
      yHold   <= '0;
    end else if (ctrl.commit) begin
      accReg  <= accNext;
      fracReg <= ctrl.fracLoad ? fracWrData : fracEff;
      yHold   <= ctrl.yLoad ? inVal : yEff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TEMP_N; i++) tempMem[i] <= '0;
    end else if (ctrl.tempWrite) begin
      tempMem[wrAddr] <= tempWrData;
    end
  end

  assign accOut = accReg;

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commit |=> $stable(accReg));

  p_start_clears_acc_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit && ctrl.sampleStart && ctrl.bSel == B_ACC &&
    ctrl.src == SRC_NONE && !ctrl.xFromTemp |=> accReg == '0);

  p_null_src_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit && ctrl.src == SRC_NONE && !ctrl.xFromTemp &&
    ctrl.bSel == B_ZERO |=> accReg == '0);

  p_yhold_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.yLoad && ctrl.src == SRC_WRK |=> yHold == $past(wrkData));

  p_temp_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.tempWrite |=> tempMem[$past(wrAddr)] == $past(tempWrData));

endmodule

// File: rtl/audfx_mac.sv
module audfx_mac
  import audfx_mac_pkg::*;
#(
  parameter int DW     = 24,
  parameter int ACC_W  = 26,
  parameter int YW     = 13,
  parameter int COEF_W = 16,
  parameter int MIX_W  = 20,
  parameter int EXT_W  = 16,
  parameter int WRK_N  = 32,
  parameter int MIX_N  = 16,
  parameter int EXT_N  = 2,
  parameter int TEMP_N = 128,
  parameter int IDX_W  = 6,
  localparam int TA_W   = $clog2(TEMP_N),
  localparam int WRK_AW = (WRK_N > 1) ? $clog2(WRK_N) : 1,
  localparam int MIX_AW = (MIX_N > 1) ? $clog2(MIX_N) : 1,
  localparam int EXT_AW = (EXT_N > 1) ? $clog2(EXT_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepValid,
  input  logic              sampleStart,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic              xUseInput,
  input  logic [1:0]        yMode,
  input  logic              bUseAcc,
  input  logic              bForceZero,
  input  logic              bNegate,
  input  logic [TA_W-1:0]   tempRdOfs,
  input  logic              yHoldLoad,
  input  logic [COEF_W-1:0] coefWord,
  input  logic [TA_W-1:0]   ringPos,
  input  logic              tempWrEn,
  input  logic [TA_W-1:0]   tempWrOfs,
  input  logic [DW-1:0]     tempWrData,
  input  logic              fracWrEn,
  input  logic [YW-1:0]     fracWrData,
  output logic [WRK_AW-1:0] wrkRdAddr,
  input  logic [DW-1:0]     wrkRdData,
  output logic [MIX_AW-1:0] mixRdAddr,
  input  logic [MIX_W-1:0]  mixRdData,
  output logic [EXT_AW-1:0] extRdAddr,
  input  logic [EXT_W-1:0]  extRdData,
  output logic [ACC_W-1:0]  accOut
);

  logic [IDX_W-1:0] mixOff, extOff;
  macCtrl_t ctrl;

  assign mixOff    = srcIdx - IDX_W'(WRK_N);
  assign extOff    = srcIdx - IDX_W'(WRK_N + MIX_N);
  assign wrkRdAddr = srcIdx[WRK_AW-1:0];
  assign mixRdAddr = mixOff[MIX_AW-1:0];
  assign extRdAddr = extOff[EXT_AW-1:0];

  audfx_mac_ctrl #(
    .IDX_W(IDX_W), .WRK_N(WRK_N), .MIX_N(MIX_N), .EXT_N(EXT_N)
  ) u_ctrl (
    .stepValid  (stepValid),
    .sampleStart(sampleStart),
    .srcIdx     (srcIdx),
    .xUseInput  (xUseInput),
    .yMode      (yMode),
    .bUseAcc    (bUseAcc),
    .bForceZero (bForceZero),
    .bNegate    (bNegate),
    .yHoldLoad  (yHoldLoad),
    .tempWrEn   (tempWrEn),
    .fracWrEn   (fracWrEn),
    .ctrl       (ctrl)
  );

  audfx_mac_dp #(
    .DW(DW), .ACC_W(ACC_W), .YW(YW), .COEF_W(COEF_W),
    .MIX_W(MIX_W), .EXT_W(EXT_W), .TEMP_N(TEMP_N)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrkData   (wrkRdData),
    .mixData   (mixRdData),
    .extData   (extRdData),
    .coefWord  (coefWord),
    .tempRdOfs (tempRdOfs),
    .tempWrOfs (tempWrOfs),
    .ringPos   (ringPos),
    .tempWrData(tempWrData),
    .fracWrData(fracWrData),
    .accOut    (accOut)
  );

endmodule

// File: tb/tb_audfx_mac.sv
module tb_audfx_mac;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stepValid, sampleStart, xUseInput, bUseAcc, bForceZero, bNegate;
  logic        yHoldLoad, tempWrEn, fracWrEn;
  logic [5:0]  srcIdx;
  logic [1:0]  yMode;
  logic [6:0]  tempRdOfs, ringPos, tempWrOfs;
  logic [15:0] coefWord;
  logic [23:0] tempWrData, wrkRdData;
  logic [12:0] fracWrData;
  logic [19:0] mixRdData;
  logic [15:0] extRdData;
  logic [4:0]  wrkRdAddr;
  logic [3:0]  mixRdAddr;
  logic [0:0]  extRdAddr;
  logic [25:0] accOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  audfx_mac dut (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .sampleStart(sampleStart),
    .srcIdx(srcIdx), .xUseInput(xUseInput), .yMode(yMode), .bUseAcc(bUseAcc),
    .bForceZero(bForceZero), .bNegate(bNegate), .tempRdOfs(tempRdOfs),
    .yHoldLoad(yHoldLoad), .coefWord(coefWord), .ringPos(ringPos),
    .tempWrEn(tempWrEn), .tempWrOfs(tempWrOfs), .tempWrData(tempWrData),
    .fracWrEn(fracWrEn), .fracWrData(fracWrData),
    .wrkRdAddr(wrkRdAddr), .wrkRdData(wrkRdData),
    .mixRdAddr(mixRdAddr), .mixRdData(mixRdData),
    .extRdAddr(extRdAddr), .extRdData(extRdData),
    .accOut(accOut)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [23:0] wrk;
    logic [19:0] mix;
    logic [15:0] ext;
    logic [15:0] coef;
    logic [25:0] exp;
  } vec_t;

  // single-step vectors: sampleStart, X from input, Y from coefficient, B zero
  localparam vec_t VECS [10] = '{
    '{6'h05, 24'h000400, 20'h00000, 16'h0000, 16'h0400, 26'h0000080},
    '{6'h05, 24'hFFFC00, 20'h00000, 16'h0000, 16'h0400, 26'h3FFFF80},
    '{6'h23, 24'h000000, 20'h00040, 16'h0000, 16'h0800, 26'h0000100},
    '{6'h23, 24'h000000, 20'h80000, 16'h0000, 16'h7FF8, 26'h2002000},
    '{6'h31, 24'h000000, 20'h00000, 16'h0010, 16'hFFF8, 26'h3FFFFFC},
    '{6'h30, 24'h000000, 20'h00000, 16'h8000, 16'h8000, 26'h2000000},
    '{6'h32, 24'h7FFFFF, 20'hFFFFF, 16'h7FFF, 16'h7FF8, 26'h0000000},
    '{6'h3F, 24'h7FFFFF, 20'hFFFFF, 16'h7FFF, 16'h7FF8, 26'h0000000},
    '{6'h1F, 24'h7FFFFF, 20'h00000, 16'h0000, 16'h0008, 26'h0001FFF},
    '{6'h1F, 24'hFFFFFF, 20'h00000, 16'h0000, 16'h0008, 26'h3FFFFFF}
  };

  task automatic check(input logic [25:0] act, input logic [25:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    stepValid = 1'b1; sampleStart = 1'b0; srcIdx = 6'h3F; xUseInput = 1'b1;
    yMode = 2'd1; bUseAcc = 1'b0; bForceZero = 1'b1; bNegate = 1'b0;
    tempRdOfs = '0; yHoldLoad = 1'b0; coefWord = '0; ringPos = '0;
    tempWrEn = 1'b0; tempWrOfs = '0; tempWrData = '0; fracWrEn = 1'b0;
    fracWrData = '0; wrkRdData = '0; mixRdData = '0; extRdData = '0;
  endtask

  task automatic doStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    stepValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(accOut, 26'h0, "R6 reset value");
    rstN = 1'b1;
    @(negedge clk);

    // vector table: R1, R3 mode 1, R5
    for (int i = 0; i < 10; i++) begin
      idle();
      sampleStart = 1'b1;
      srcIdx = VECS[i].idx; wrkRdData = VECS[i].wrk;
      mixRdData = VECS[i].mix; extRdData = VECS[i].ext;
      coefWord = VECS[i].coef;
      doStep();
      check(accOut, VECS[i].exp, "R1/R5 vector");
      if (i == 0) check({21'h0, wrkRdAddr}, 26'd5, "R1 work address");
      if (i == 2) check({22'h0, mixRdAddr}, 26'd3, "R1 mix address");
      if (i == 4) check({25'h0, extRdAddr}, 26'd1, "R1 ext address");
    end

    // R9 ring wrap + R4 B from scratch and negation
    idle(); sampleStart = 1'b1; ringPos = 7'd126; tempWrEn = 1'b1;
    tempWrOfs = 7'd3; tempWrData = 24'h000123;
    doStep();
    check(accOut, 26'h0, "R9 write step acc");
    idle(); ringPos = 7'd127; tempRdOfs = 7'd2; bForceZero = 1'b0;
    doStep();
    check(accOut, 26'h0000123, "R4 B from scratch R9 wrap");
    idle(); ringPos = 7'd127; tempRdOfs = 7'd2; bForceZero = 1'b0; bNegate = 1'b1;
    doStep();
    check(accOut, 26'h3FFFEDD, "R4 negated B");

    // R2 X from scratch, R9 negative word
    idle(); tempWrEn = 1'b1; tempWrOfs = 7'd10; tempWrData = 24'hFFF000;
    doStep();
    idle(); xUseInput = 1'b0; tempRdOfs = 7'd10; coefWord = 16'h0400;
    doStep();
    check(accOut, 26'h3FFFE00, "R2 X from scratch");
    idle(); xUseInput = 1'b0; tempRdOfs = 7'd10; bForceZero = 1'b0;
    doStep();
    check(accOut, 26'h3FFF000, "R4 B scratch sign extension");

    // R9 no write without stepValid
    idle(); stepValid = 1'b0; tempWrEn = 1'b1; tempWrOfs = 7'd20; tempWrData = 24'h000555;
    doStep();
    idle(); tempRdOfs = 7'd20; bForceZero = 1'b0;
    doStep();
    check(accOut, 26'h0, "R9 write ignored when invalid");

    // R4/R8 accumulate chain
    idle(); sampleStart = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h000400; coefWord = 16'h0400;
    doStep();
    check(accOut, 26'h0000080, "R5 chain start");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; coefWord = 16'h0400;
    bForceZero = 1'b0; bUseAcc = 1'b1;
    doStep();
    check(accOut, 26'h0000100, "R4 B from accumulator");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; coefWord = 16'h0400;
    bForceZero = 1'b0; bUseAcc = 1'b1;
    doStep();
    check(accOut, 26'h0000180, "R4 accumulate again");

    // R6 hold while invalid
    idle(); stepValid = 1'b0; srcIdx = 6'h05; wrkRdData = 24'h7FFFFF; coefWord = 16'h7FF8;
    doStep();
    check(accOut, 26'h0000180, "R6 hold when invalid");

    idle(); sampleStart = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h000400; coefWord = 16'h0400;
    bForceZero = 1'b0; bUseAcc = 1'b1;
    doStep();
    check(accOut, 26'h0000080, "R8 previous acc zero at start");

    // R7 Y holding register, R3 modes 2 and 3
    idle(); sampleStart = 1'b1; yHoldLoad = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h123800;
    yMode = 2'd2;
    doStep();
    check(accOut, 26'h0, "R7 old Y used in load step");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd2;
    doStep();
    check(accOut, 26'h0000247, "R3 Y upper slice");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd3;
    doStep();
    check(accOut, 26'h0000380, "R3 Y lower slice");
    idle(); yHoldLoad = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h008000;
    doStep();
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd3;
    doStep();
    check(accOut, 26'h3FFF800, "R3 Y lower slice negative R7");
    idle(); sampleStart = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd3;
    doStep();
    check(accOut, 26'h0, "R8 Y hold zero at start");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd3;
    doStep();
    check(accOut, 26'h0, "R8 Y hold cleared after start");

    // R10 fraction register, R3 mode 0
    idle(); sampleStart = 1'b1; fracWrEn = 1'b1; fracWrData = 13'h1FFF;
    srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd0;
    doStep();
    check(accOut, 26'h0, "R8 fraction zero at start");
    idle(); srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd0;
    doStep();
    check(accOut, 26'h0001FFF, "R10 fraction loaded R3 zero-extend");
    idle(); sampleStart = 1'b1; srcIdx = 6'h05; wrkRdData = 24'h000400; yMode = 2'd0;
    doStep();
    check(accOut, 26'h0, "R8 fraction hidden at start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule